// File: doc/BRIEF.md
# Machine-Mode Shadow-Stack PMP Verdict Unit

This unit gives the final pass-or-fault verdict for one machine-mode physical access once the PMP priority search has already run. It receives the index of the entry that won the search (or a flag saying nothing matched), the read and write permissions of that entry, and the kind of access. The access is either an ordinary load or store, or one of the three shadow-stack operations: push, pop and swap.

A selector from the security configuration register names the one PMP entry that holds the machine-mode shadow stack. When the lockdown bit is set, every shadow-stack operation must land in that entry, and ordinary stores must stay out of it. When lockdown is clear, the selector has no effect and only ordinary read and write permissions apply. The PMP configuration has no spare encoding that could mark an entry as a shadow stack, so the selector is the only way the entry is identified.

Each request with `reqValid` high produces a registered verdict on the next cycle. The verdict says allow or fault. A fault also reports whether it is a load access fault or a store/AMO access fault.

Top module: `sspmp_m_guard`

## Requirements
- R1: While reset is asserted and after it is released, `rspValid`, `rspAllow`, `rspFault` and `rspKind` are 0 until the first request.
- R2: A request sampled with `reqValid`=1 on a rising edge produces `rspValid`=1 after that edge. A cycle with `reqValid`=0 produces `rspValid`=0.
- R3: When an entry matched (`noMatch`=0), a push (`ssOp`=01) needs `permW`=1, a pop (`ssOp`=10) needs `permR`=1, and a swap (`ssOp`=11) needs both. A missing permission gives a fault.
- R4: When an entry matched, an ordinary access (`ssOp`=00) faults if it is a load (`isStore`=0) without `permR`, or a store (`isStore`=1) without `permW`.
- R5: With `noMatch`=1, no permission is checked. An ordinary access is allowed, and a shadow-stack operation is allowed unless R6 applies.
- R6: With `lockdown`=1, a push, pop or swap faults if `noMatch`=1 or if `matchIdx` differs from `ssSel`.
- R7: With `lockdown`=1, an ordinary store that matched entry `ssSel` faults, even when `permW`=1. An ordinary load from that entry follows R4 only.
- R8: With `lockdown`=0, the value of `ssSel` has no effect on the verdict.
- R9: On a fault, `rspKind` is 1 (store/AMO access fault) for push, swap and ordinary store, and 0 (load access fault) for pop and ordinary load. `rspKind` is 0 whenever there is no fault.
- R10: While `rspValid`=1, exactly one of `rspAllow` and `rspFault` is 1. While `rspValid`=0, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present this cycle |
| matchIdx | input | IDX_W | Index of the PMP entry that matched |
| noMatch | input | 1 | No PMP entry matched |
| permR | input | 1 | Read permission of the matched entry |
| permW | input | 1 | Write permission of the matched entry |
| isStore | input | 1 | For an ordinary access: 1 store, 0 load |
| ssOp | input | 2 | 00 ordinary, 01 push, 10 pop, 11 swap |
| lockdown | input | 1 | Machine-mode lockdown enable |
| ssSel | input | IDX_W | Entry selected as the machine-mode shadow stack |
| rspValid | output | 1 | Verdict present |
| rspAllow | output | 1 | Access allowed |
| rspFault | output | 1 | Access fault |
| rspKind | output | 1 | Fault kind: 1 store/AMO, 0 load |

## Verification
A permission fault and a lockdown fault can both arise from one request. One example is a swap with write permission missing that also hits an entry other than the selected one. Another is an ordinary store without write permission that lands in the selected entry. The bench produces these overlaps by sweeping every combination of op, store flag, lockdown, match flag, both permissions, matched index and selector in a 3-bit index configuration. It then checks that a single fault comes out, with the kind set by the operation and not by which rule fired.

// File: rtl/sspmp_pkg.sv
package sspmp_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_PUSH = 2'b01,
    OP_POP  = 2'b10,
    OP_SWAP = 2'b11
  } ssOp_e;

  // strobes handed from decode control to the verdict datapath
  typedef struct packed {
    logic needRd;      // access requires read permission
    logic needWr;      // access requires write permission
    logic ssAccess;    // shadow-stack operation
    logic plainStore;  // ordinary store
    logic storeKind;   // fault would be store/AMO class
  } chkStrobe_t;

endpackage

// File: rtl/sspmp_ctrl.sv
module sspmp_ctrl
  import sspmp_pkg::*;
(
  input  ssOp_e      ssOp,
  input  logic       isStore,
  output chkStrobe_t strb
);

  always_comb begin
    strb = '0;
    unique case (ssOp)
      OP_PUSH: begin
        strb.needWr    = 1'b1;
        strb.ssAccess  = 1'b1;
        strb.storeKind = 1'b1;
      end
      OP_POP: begin
        strb.needRd   = 1'b1;
        strb.ssAccess = 1'b1;
      end
      OP_SWAP: begin
        strb.needRd    = 1'b1;
        strb.needWr    = 1'b1;
        strb.ssAccess  = 1'b1;
        strb.storeKind = 1'b1;
      end
      default: begin
        strb.needRd     = !isStore;
        strb.needWr     = isStore;
        strb.plainStore = isStore;
        strb.storeKind  = isStore;
      end
    endcase
  end

  // R3
  always_comb begin
    ss_needs_perm_chk: assert (!strb.ssAccess || strb.needRd || strb.needWr);
  end

endmodule

// File: rtl/sspmp_dp.sv
module sspmp_dp
  import sspmp_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  chkStrobe_t       strb,
  input  logic [IDX_W-1:0] matchIdx,
  input  logic             noMatch,
  input  logic             permR,
  input  logic             permW,
  input  logic             lockdown,
  input  logic [IDX_W-1:0] ssSel,
  output logic             rspValid,
  output logic             rspAllow,
  output logic             rspFault,
  output logic             rspKind
);

  logic hitSel;
  logic permFail;
  logic lockFail;
  logic faultNow;

  always_comb begin
    hitSel   = !noMatch && (matchIdx == ssSel);
    permFail = !noMatch &&
               ((strb.needRd && !permR) || (strb.needWr && !permW));
    lockFail = lockdown &&
               ((strb.ssAccess && !hitSel) || (strb.plainStore && hitSel));
    faultNow = permFail || lockFail;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspAllow <= 1'b0;
      rspFault <= 1'b0;
      rspKind  <= 1'b0;
    end else begin
      rspValid <= reqValid;
      rspAllow <= reqValid && !faultNow;
      rspFault <= reqValid && faultNow;
      rspKind  <= reqValid && faultNow && strb.storeKind;
    end
  end

  // R10
  verdict_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspAllow != rspFault));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (!rspAllow && !rspFault && !rspKind));

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R6
  lock_wrong_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && lockdown && strb.ssAccess &&
     (noMatch || matchIdx != ssSel)) |=> rspFault);

  // R7
  lock_plain_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && lockdown && strb.plainStore && !noMatch &&
     matchIdx == ssSel) |=> (rspFault && rspKind));

endmodule

// File: rtl/sspmp_m_guard.sv
module sspmp_m_guard
  import sspmp_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [IDX_W-1:0] matchIdx,
  input  logic             noMatch,
  input  logic             permR,
  input  logic             permW,
  input  logic             isStore,
  input  logic [1:0]       ssOp,
  input  logic             lockdown,
  input  logic [IDX_W-1:0] ssSel,
  output logic             rspValid,
  output logic             rspAllow,
  output logic             rspFault,
  output logic             rspKind
);

  chkStrobe_t strb;

  sspmp_ctrl u_ctrl (
    .ssOp    (ssOp_e'(ssOp)),
    .isStore (isStore),
    .strb    (strb)
  );

  sspmp_dp #(.IDX_W(IDX_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .strb     (strb),
    .matchIdx (matchIdx),
    .noMatch  (noMatch),
    .permR    (permR),
    .permW    (permW),
    .lockdown (lockdown),
    .ssSel    (ssSel),
    .rspValid (rspValid),
    .rspAllow (rspAllow),
    .rspFault (rspFault),
    .rspKind  (rspKind)
  );

endmodule

// File: tb/sspmp_m_guard_tb.sv
module sspmp_m_guard_tb;

  localparam int CLK_PERIOD = 10;
  localparam int IW         = 3;
  localparam int N_IDX      = 1 << IW;
  localparam int WATCHDOG   = 100000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [IW-1:0] matchIdx = '0;
  logic          noMatch = 1'b0;
  logic          permR = 1'b0;
  logic          permW = 1'b0;
  logic          isStore = 1'b0;
  logic [1:0]    ssOp = 2'b00;
  logic          lockdown = 1'b0;
  logic [IW-1:0] ssSel = '0;
  logic          rspValid, rspAllow, rspFault, rspKind;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sspmp_m_guard #(.IDX_W(IW)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .matchIdx(matchIdx),
    .noMatch(noMatch), .permR(permR), .permW(permW), .isStore(isStore),
    .ssOp(ssOp), .lockdown(lockdown), .ssSel(ssSel),
    .rspValid(rspValid), .rspAllow(rspAllow), .rspFault(rspFault),
    .rspKind(rspKind)
  );

  task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got valid/allow/fault/kind=%b expected %b", req, got, exp);
    end
  endtask

  // drive at a falling edge, sample at the following falling edge
  task automatic runOne(input int op, input int st, input int lk, input int nm,
                        input int r, input int w, input int idx, input int sel);
    bit needRd, needWr, ssA, plainSt, storeLike, hit, pf, lf, flt;
    string tag;
    reqValid = 1'b1;
    ssOp     = op[1:0];
    isStore  = st[0];
    lockdown = lk[0];
    noMatch  = nm[0];
    permR    = r[0];
    permW    = w[0];
    matchIdx = idx[IW-1:0];
    ssSel    = sel[IW-1:0];
    ssA       = (op != 0);
    needRd    = (op == 2) || (op == 3) || (op == 0 && st == 0);
    needWr    = (op == 1) || (op == 3) || (op == 0 && st == 1);
    plainSt   = (op == 0) && (st == 1);
    storeLike = (op == 1) || (op == 3) || plainSt;
    hit       = (nm == 0) && (idx == sel);
    pf        = (nm == 0) && ((needRd && r == 0) || (needWr && w == 0));
    lf        = (lk == 1) && ((ssA && !hit) || (plainSt && hit));
    flt       = pf || lf;
    if (lk == 1 && ssA && !hit)        tag = "R6";
    else if (lk == 1 && plainSt && hit) tag = "R7";
    else if (nm == 1)                   tag = "R5";
    else if (lk == 0 && idx != sel)     tag = "R8";
    else if (ssA)                       tag = "R3";
    else                                tag = "R4";
    @(negedge clk);
    check(tag, {rspValid, rspAllow, rspFault, 1'b0}, {1'b1, !flt, flt, 1'b0});
    check("R9", {3'b000, rspKind}, {3'b000, flt && storeLike});
  endtask

  initial begin
    int vec = 0;
    repeat (3) @(negedge clk);
    // R1
    check("R1", {rspValid, rspAllow, rspFault, rspKind}, 4'b0000);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", {rspValid, rspAllow, rspFault, rspKind}, 4'b0000);
    for (int op = 0; op < 4; op++)
      for (int st = 0; st < 2; st++)
        for (int lk = 0; lk < 2; lk++)
          for (int nm = 0; nm < 2; nm++)
            for (int r = 0; r < 2; r++)
              for (int w = 0; w < 2; w++)
                for (int idx = 0; idx < N_IDX; idx++)
                  for (int sel = 0; sel < N_IDX; sel++) begin
                    runOne(op, st, lk, nm, r, w, idx, sel);
                    vec++;
                    if (vec % 64 == 0) begin
                      reqValid = 1'b0;
                      @(negedge clk);
                      // R2 R10
                      check("R2", {rspValid, rspAllow, rspFault, rspKind}, 4'b0000);
                    end
                  end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule